// File: doc/BRIEF.md
# Nonvolatile SRAM Store and Recall Controller

This block holds the control logic of a static RAM in which every cell has a shadow copy that survives power loss. A host reaches it over an SRAM-style bus of chip enable, write enable, output enable, address and data. Every signal is sampled on a system clock, and each clock with chip enable low counts as one access. The block copies the whole working array into the shadow array (a store) or copies the shadow array back (a recall). Both copies take effect in a single cycle at the end of a timed busy period. Bus access is shut off while either copy runs.

A store has three possible triggers. An external agent can pull the shared open-drain handshake line low. Software can issue six reads to a fixed chain of addresses. The power-fail input can also start one. The block pulls the handshake line low itself for as long as a store runs. The surrounding logic forms the line level as the wired-AND of every driver and feeds it back on `hs_in`. A recall runs by itself when reset is released, and software can also start one. After any store or recall, writes stay locked until write enable falls again.

Top module: `nvsram_ctrl`

## Requirements
- R1: While reset is asserted and for RECALL_CYC cycles after it, a recall runs. During that time no read is valid (`rdata_valid`=0, `rdata`=0). Afterwards the working array holds the shadow contents, which are not changed by reset.
- R2: In idle with `hs_in` high, an access with `we_n` low writes `wdata` to entry `addr[IDXW-1:0]`. An access with `we_n` high and `oe_n` low returns that entry on `rdata` with `rdata_valid`=1 in the same cycle.
- R3: Six read accesses to UNLOCK_0..UNLOCK_4 and then a final key start a nonvolatile operation. The key STORE_KEY starts a store and RECALL_KEY starts a recall. Only `addr[15:0]` is compared, and idle cycles between the accesses are allowed.
- R4: A write access, or a read to an address that is not the next in the chain, returns the detector to its first step. A sixth read that follows such a break starts nothing.
- R5: When `hs_in` is low in idle, a store starts. No write takes effect while `hs_in` is low.
- R6: During a store, `hs_drive_low` is 1 for exactly STORE_CYC cycles and no read is valid. At the end, the shadow array takes the working array's contents.
- R7: After a store ends, no read is valid and no write takes effect until `hs_in` is sampled high.
- R8: With `pwr_fail` high in idle, a store starts only if a write has taken effect since the last store or recall. Otherwise no store starts.
- R9: After a store or recall completes, a write takes effect only in a cycle where `we_n` is low and was high in the previous cycle.
- R10: A recall copies every shadow entry into the working array in one cycle and clears the written-since-last-copy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Bus address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, zero when not valid |
| rdata_valid | output | 1 | Read data valid this cycle |
| hs_in | input | 1 | Sensed level of the shared handshake line |
| hs_drive_low | output | 1 | Pulls the handshake line low while a store runs |
| pwr_fail | input | 1 | Power-down warning, requests an automatic store |

## Verification
The assertions assume that `hs_in` is the wired-AND of `hs_drive_low` and an external level. As long as the block drives the line, it must read low, and it must rise in the cycle after the drive is released unless an outside agent holds it. The bench builds `hs_in` from exactly that wired-AND and only changes the external level between operations. The assertions also take each bus access as one clocked cycle with stable inputs. The bench drives every input on the falling clock edge and separates accesses with idle cycles, so the sequence detector sees each address exactly once.

// File: rtl/nvs_pkg.sv
// Shared types for the nonvolatile SRAM controller.
package nvs_pkg;

    // Controller operating state
    typedef enum logic [1:0] {
        ST_RECALL  = 2'd0,
        ST_IDLE    = 2'd1,
        ST_STORE   = 2'd2,
        ST_WAIT_HS = 2'd3
    } nvs_state_e;

    // Operation requested by the software address chain
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_STORE  = 2'd1,
        OP_RECALL = 2'd2
    } nvs_op_e;

endpackage

// File: rtl/nvs_seq_detect.sv
// Software unlock chain detector.
// Follows six read accesses: five unlock addresses and then a final key that
// picks store or recall. Only the low 16 address bits are compared.
// Assumes: `access` is asserted for one cycle per bus access the controller accepts.
module nvs_seq_detect
    import nvs_pkg::*;
#(
    parameter logic [15:0] UNLOCK_0   = 16'h4E38,
    parameter logic [15:0] UNLOCK_1   = 16'hB1C7,
    parameter logic [15:0] UNLOCK_2   = 16'h83E0,
    parameter logic [15:0] UNLOCK_3   = 16'h7C1F,
    parameter logic [15:0] UNLOCK_4   = 16'h703F,
    parameter logic [15:0] STORE_KEY  = 16'h8FC0,
    parameter logic [15:0] RECALL_KEY = 16'h4C63
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        access,
    input  logic        is_read,
    input  logic [15:0] addr16,
    output nvs_op_e     op_req,
    output logic [2:0]  step
);

    localparam logic [2:0] LAST_STEP = 3'd5;

    logic [15:0] expect_addr;

    // Select the address that the current step expects
    always_comb begin
        case (step)
            3'd0:    expect_addr = UNLOCK_0;
            3'd1:    expect_addr = UNLOCK_1;
            3'd2:    expect_addr = UNLOCK_2;
            3'd3:    expect_addr = UNLOCK_3;
            default: expect_addr = UNLOCK_4;
        endcase
    end

    // Advance on a matching read, go back to the first step on anything else
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= 3'd0;
        end else if (access) begin
            if (!is_read || step == LAST_STEP)
                step <= 3'd0;
            else if (addr16 == expect_addr)
                step <= step + 3'd1;
            else
                step <= 3'd0;
        end
    end

    // Decode the final key into an operation request
    always_comb begin
        op_req = OP_NONE;
        if (access && is_read && step == LAST_STEP) begin
            if (addr16 == STORE_KEY)
                op_req = OP_STORE;
            else if (addr16 == RECALL_KEY)
                op_req = OP_RECALL;
        end
    end

endmodule

// File: rtl/nvs_op_timer.sv
// Down-counter that times a store or recall.
// `done` is high while the count is zero. Loading N-1 therefore gives a busy
// period of N cycles. Assumes load values fit in CW bits.
module nvs_op_timer #(
    parameter int CW      = 8,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt;

    // Load on request, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CW'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/nvs_mem_pair.sv
// Working array with a shadow copy per entry.
// A store copies every working entry to its shadow. A recall does the reverse.
// Each copy takes effect in one cycle. Neither array is reset: the shadow
// models nonvolatile content. Assumes store_all and recall_all are never high together.
module nvs_mem_pair #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            store_all,
    input  logic            recall_all,
    input  logic [IDXW-1:0] rd_idx,
    output logic [DW-1:0]   rd_data
);

    logic [DW-1:0] work_q   [DEPTH];
    logic [DW-1:0] shadow_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
        // Working entry: a recall overrides a bus write
        always_ff @(posedge clk) begin
            if (recall_all)
                work_q[gi] <= shadow_q[gi];
            else if (wr_en && wr_idx == IDXW'(gi))
                work_q[gi] <= wr_data;
        end

        // Shadow entry: takes the working value on a store
        always_ff @(posedge clk) begin
            if (store_all)
                shadow_q[gi] <= work_q[gi];
        end
    end

    assign rd_data = work_q[rd_idx];

endmodule

// File: rtl/nvsram_ctrl.sv
// Nonvolatile SRAM store/recall controller (top).
// Decodes a clocked SRAM-style bus and chooses between three store triggers
// (handshake line, software chain, power fail) and the software recall.
// Times each operation and blocks bus access while one runs. Locks writes
// after every copy until write enable falls again.
// Assumes: hs_in is the wired-AND of hs_drive_low and any external driver.
module nvsram_ctrl
    import nvs_pkg::*;
#(
    parameter int          AW         = 17,
    parameter int          DW         = 8,
    parameter int          DEPTH      = 16,
    parameter int          STORE_CYC  = 40,
    parameter int          RECALL_CYC = 20,
    parameter logic [15:0] UNLOCK_0   = 16'h4E38,
    parameter logic [15:0] UNLOCK_1   = 16'hB1C7,
    parameter logic [15:0] UNLOCK_2   = 16'h83E0,
    parameter logic [15:0] UNLOCK_3   = 16'h7C1F,
    parameter logic [15:0] UNLOCK_4   = 16'h703F,
    parameter logic [15:0] STORE_KEY  = 16'h8FC0,
    parameter logic [15:0] RECALL_KEY = 16'h4C63
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_valid,
    input  logic          hs_in,
    output logic          hs_drive_low,
    input  logic          pwr_fail
);

    localparam int IDXW = $clog2(DEPTH);
    localparam int TMAX = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int TCW  = $clog2(TMAX + 1);

    nvs_state_e     state;
    nvs_op_e        seq_op;
    logic [2:0]     seq_step;
    logic           we_prev, lock_q, dirty_q, we_fall;
    logic           idle, rd_acc, wr_acc, mem_we;
    logic           start_store, start_recall, tmr_done;
    logic           store_all, recall_all;
    logic [DW-1:0]  mem_rd;
    logic [TCW-1:0] tmr_val;

    // Bus decode and write qualification
    assign idle    = (state == ST_IDLE);
    assign rd_acc  = !ce_n && we_n;
    assign wr_acc  = !ce_n && !we_n;
    assign we_fall = we_prev && !we_n;
    assign mem_we  = idle && wr_acc && hs_in && (!lock_q || we_fall);

    nvs_seq_detect #(
        .UNLOCK_0(UNLOCK_0), .UNLOCK_1(UNLOCK_1), .UNLOCK_2(UNLOCK_2),
        .UNLOCK_3(UNLOCK_3), .UNLOCK_4(UNLOCK_4),
        .STORE_KEY(STORE_KEY), .RECALL_KEY(RECALL_KEY)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .access  (idle && !ce_n && hs_in),
        .is_read (we_n),
        .addr16  (addr[15:0]),
        .op_req  (seq_op),
        .step    (seq_step)
    );

    // Trigger arbitration in idle: handshake line, then power fail, then software
    always_comb begin
        start_store  = 1'b0;
        start_recall = 1'b0;
        if (idle) begin
            if (!hs_in || (pwr_fail && dirty_q) || seq_op == OP_STORE)
                start_store = 1'b1;
            else if (seq_op == OP_RECALL)
                start_recall = 1'b1;
        end
    end

    assign tmr_val = start_store ? TCW'(STORE_CYC - 1) : TCW'(RECALL_CYC - 1);

    nvs_op_timer #(.CW(TCW), .RST_VAL(RECALL_CYC - 1)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_store || start_recall),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign store_all  = (state == ST_STORE)  && tmr_done;
    assign recall_all = (state == ST_RECALL) && tmr_done;

    // Operation state machine; reset enters the power-up recall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RECALL;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_store)       state <= ST_STORE;
                    else if (start_recall) state <= ST_RECALL;
                end
                ST_STORE:   if (tmr_done) state <= ST_WAIT_HS;
                ST_WAIT_HS: if (hs_in)    state <= ST_IDLE;
                default:    if (tmr_done) state <= ST_IDLE;
            endcase
        end
    end

    // Write lock, written-since-copy flag and previous write-enable level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_prev <= 1'b1;
            lock_q  <= 1'b1;
            dirty_q <= 1'b0;
        end else begin
            we_prev <= we_n;
            if (store_all || recall_all) begin
                lock_q  <= 1'b1;
                dirty_q <= 1'b0;
            end else begin
                if (we_fall) lock_q  <= 1'b0;
                if (mem_we)  dirty_q <= 1'b1;
            end
        end
    end

    nvs_mem_pair #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk        (clk),
        .wr_en      (mem_we),
        .wr_idx     (addr[IDXW-1:0]),
        .wr_data    (wdata),
        .store_all  (store_all),
        .recall_all (recall_all),
        .rd_idx     (addr[IDXW-1:0]),
        .rd_data    (mem_rd)
    );

    // Read path and handshake drive
    assign rdata_valid  = idle && rd_acc && !oe_n && hs_in;
    assign rdata        = rdata_valid ? mem_rd : '0;
    assign hs_drive_low = (state == ST_STORE);

endmodule

// File: rtl/nvsram_ctrl_chk.sv
// Property checker for nvsram_ctrl, attached through bind.
// Assumes hs_in is the wired-AND of hs_drive_low and an external level.
module nvsram_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_in,
    input logic       hs_drive_low,
    input logic       rdata_valid,
    input logic       mem_we,
    input logic       timer_done,
    input logic       dirty,
    input logic [2:0] seq_step
);

    assert_seq_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_step <= 3'd5);

    assert_line_low_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_in |-> !mem_we);

    assert_store_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hs_drive_low |-> !rdata_valid);

    assert_drive_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_drive_low && !timer_done) |=> hs_drive_low);

    assert_release_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_drive_low) |-> !rdata_valid);

    assert_store_clears_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_drive_low) |-> !dirty);

endmodule

bind nvsram_ctrl nvsram_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hs_in        (hs_in),
    .hs_drive_low (hs_drive_low),
    .rdata_valid  (rdata_valid),
    .mem_we       (mem_we),
    .timer_done   (tmr_done),
    .dirty        (dirty_q),
    .seq_step     (seq_step)
);

// File: tb/test_nvsram_ctrl.sv
// Self-checking bench for nvsram_ctrl: a table walk, then directed tests.
module test_nvsram_ctrl;

    localparam int AW = 17, DW = 8, DEPTH = 16;
    localparam int STORE_CYC = 40, RECALL_CYC = 20;
    localparam logic [15:0] K0 = 16'h4E38, K1 = 16'hB1C7, K2 = 16'h83E0,
                            K3 = 16'h7C1F, K4 = 16'h703F;
    localparam logic [15:0] KST = 16'h8FC0, KRC = 16'h4C63;

    // Table: {address, write data}; low four address bits are distinct
    localparam logic [24:0] VEC [8] = '{
        {17'h10000, 8'hA5}, {17'h00121, 8'h3C}, {17'h0ABC2, 8'hF0},
        {17'h1F003, 8'h0F}, {17'h00054, 8'h81}, {17'h12345, 8'h7E},
        {17'h0FFF6, 8'h55}, {17'h08887, 8'hAA}};

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, pwr_fail = 1'b0, ext_hs_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0, rdata;
    logic rdata_valid, hs_drive_low, hs_in;

    logic [DW-1:0] sr [DEPTH];
    logic [DW-1:0] sh [DEPTH];
    int errors = 0, checks = 0;

    always #5 clk = ~clk;
    assign hs_in = ext_hs_n & ~hs_drive_low;

    nvsram_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH),
                  .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) i_nvsram_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_valid(rdata_valid),
        .hs_in(hs_in), .hs_drive_low(hs_drive_low), .pwr_fail(pwr_fail));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                            output logic v);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
        #1;
        d = rdata; v = rdata_valid;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                            input string req);
        logic [DW-1:0] d;
        logic v;
        bus_read(a, d, v);
        chk(v == 1'b1, req, v, 1);
        chk(d == exp, req, d, exp);
    endtask

    task automatic run_chain(input logic [15:0] last);
        logic [DW-1:0] d;
        logic v;
        bus_read({1'b0, K0}, d, v);
        bus_read({1'b1, K1}, d, v);   // upper bit set: must be ignored
        bus_read({1'b0, K2}, d, v);
        bus_read({1'b0, K3}, d, v);
        bus_read({1'b0, K4}, d, v);
        bus_read({1'b0, last}, d, v);
    endtask

    // Count cycles with the drive low, starting at the current negedge
    task automatic measure_store(output int n);
        n = 0;
        while (hs_drive_low && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Confirm that no store begins during the next cycles
    task automatic expect_no_store(input int cyc, input string req);
        int seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (hs_drive_low) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failed check and still reports
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        logic v;
        int n;

        // R1: reset state and power-up recall window
        do_reset();
        chk(hs_drive_low == 1'b0, "R1 no drive after reset", hs_drive_low, 0);
        bus_read(17'h00001, d, v);
        chk(v == 1'b0, "R1 read blocked during recall", v, 0);
        chk(d == '0, "R1 data zero during recall", d, 0);
        repeat (RECALL_CYC + 2) @(negedge clk);

        // R2: table walk, write then read back each entry
        foreach (VEC[i]) begin
            bus_write(VEC[i][24:8], VEC[i][7:0]);
            sr[VEC[i][11:8]] = VEC[i][7:0];
            read_chk(VEC[i][24:8], VEC[i][7:0], "R2 table readback");
        end

        // R8/R6: automatic store with pending writes, exact drive length
        @(negedge clk);
        pwr_fail = 1'b1;
        @(negedge clk);
        measure_store(n);
        chk(n == STORE_CYC, "R6 R8 auto store length", n, STORE_CYC);
        for (int i = 0; i < 8; i++) sh[i] = sr[i];
        // R8: nothing written since, so no further store
        expect_no_store(10, "R8 skip when clean");
        pwr_fail = 1'b0;

        // R3/R10/R9: software recall; write enable falls during the recall
        bus_write(17'h00000, 8'h11);
        run_chain(KRC);
        we_n = 1'b0;
        repeat (RECALL_CYC + 3) @(negedge clk);
        for (int i = 0; i < 8; i++) sr[i] = sh[i];
        ce_n = 1'b0; addr = 17'h00000; wdata = 8'h99;  // write enable held low
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        read_chk(17'h00000, sh[0], "R3 R10 recall restored, R9 held-low write blocked");
        read_chk(17'h00001, sh[1], "R10 recall entry 1");
        bus_write(17'h00000, 8'h99);
        sr[0] = 8'h99;
        read_chk(17'h00000, 8'h99, "R9 write after new falling edge");

        // R3/R6: software store, one chain address with a high bit set
        bus_write(17'h00001, 8'h22);
        sr[1] = 8'h22;
        run_chain(KST);
        measure_store(n);
        chk(n == STORE_CYC, "R3 R6 software store length", n, STORE_CYC);
        for (int i = 0; i < 8; i++) sh[i] = sr[i];

        // R4: a write inside the chain cancels it
        bus_read({1'b0, K0}, d, v);
        bus_read({1'b0, K1}, d, v);
        bus_read({1'b0, K2}, d, v);
        bus_read({1'b0, K3}, d, v);
        bus_read({1'b0, K4}, d, v);
        bus_write(17'h00009, 8'h5A);
        sr[9] = 8'h5A;
        bus_read({1'b0, KST}, d, v);
        expect_no_store(8, "R4 write breaks chain");
        // R4: a wrong address inside the chain cancels it
        bus_read({1'b0, K0}, d, v);
        bus_read({1'b0, K1}, d, v);
        bus_read({1'b0, K2}, d, v);
        bus_read({1'b0, K3}, d, v);
        bus_read(17'h01234, d, v);
        bus_read({1'b0, K4}, d, v);
        bus_read({1'b0, KST}, d, v);
        expect_no_store(8, "R4 wrong address breaks chain");

        // R5/R7: external handshake store, line held low past completion
        @(negedge clk);
        ext_hs_n = 1'b0;
        @(negedge clk);
        chk(hs_drive_low == 1'b1, "R5 external request starts store", hs_drive_low, 1);
        bus_write(17'h00003, 8'hEE);  // must be blocked
        measure_store(n);
        for (int i = 0; i < DEPTH; i++) sh[i] = sr[i];
        bus_read(17'h00003, d, v);
        chk(v == 1'b0, "R7 read blocked until line high", v, 0);
        bus_write(17'h00004, 8'hDD);  // must be blocked
        ext_hs_n = 1'b1;
        repeat (2) @(negedge clk);
        read_chk(17'h00003, sr[3], "R5 write during store blocked");
        read_chk(17'h00004, sr[4], "R5 R7 write while line low blocked");

        // R1: power cycle restores the shadow, discarding the unstored write
        bus_write(17'h00002, 8'h33);
        do_reset();
        repeat (RECALL_CYC + 2) @(negedge clk);
        read_chk(17'h00002, sh[2], "R1 power-up recall restores shadow");
        read_chk(17'h00009, sh[9], "R1 power-up recall entry 9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule